// File: doc/BRIEF.md
# Virtual Segment Router and Translation Fault Classifier

This block sits between a 32-bit address generator and a page-table cache. Each cycle it can accept one virtual address and the current privilege level, and it decides which fixed region the address falls into. The address then takes one of three routes: it is turned straight into a physical address, it is passed on for page-table lookup, or it is refused because the current privilege may not touch that region. The answer comes back registered, one cycle after the request.

A second, independent input carries the outcome of a translation attempt: a result code, the faulting address and the access type. For every failing result the block picks the exception kind, taking into account whether the access was a store or an instruction fetch and whether the dedicated inhibit exceptions are enabled. In the same edge it records the faulting address, refreshes the page-number field of the context register and rewrites the entry-high register around its address-space identifier. Both of those kept fields can be loaded through a small write port.

Top module: `seg_fault_unit`

## Requirements
- R1: A virtual address in 0x00000000..0x7FFFFFFF is open to every privilege level; with the error-level input high it is routed unmapped (route 0) with physical address equal to the virtual address, otherwise it is routed to the page table (route 1) with the virtual address on rsp_addr.
- R2: Addresses 0x80000000..0x9FFFFFFF are unmapped (route 0) with physical address = address - 0x80000000 in kernel level; in any other level they are refused (route 2, rsp_addr zero).
- R3: Addresses 0xA0000000..0xBFFFFFFF are unmapped (route 0) with physical address = address - 0xA0000000 in kernel level; otherwise refused (route 2, rsp_addr zero).
- R4: Addresses 0xC0000000..0xDFFFFFFF go to the page table (route 1) in kernel or supervisor level and 0xE0000000..0xFFFFFFFF only in kernel level; all other cases are refused. Level encoding: 0 kernel, 1 supervisor, 2 user, 3 kernel.
- R5: After reset every output is zero; rsp_valid is high exactly in the cycle after a cycle with req_valid high, and rsp_route/rsp_addr hold their last value when no request arrives.
- R6: Result codes: 0 success, 1 refused, 2 no entry, 3 entry not valid, 4 write to clean page, 5 read inhibited, 6 execute inhibited, 7 treated as refused. Access types: 0 load, 1 store, 2 fetch, 3 treated as load. A refused result gives exception 1 (address error, store) for a store and 0 (address error, load) otherwise.
- R7: Results 2 and 3 give exception 3 (page-table store) for a store and 2 (page-table load) otherwise; exc_refill is high only for result 2.
- R8: Result 4 gives exception 4 (modify). Results 5 and 6 give exceptions 5 and 6 respectively when inhibit_exc_en is high, and exception 2 otherwise.
- R9: exc_fetch_na is high with every exception whose access type was fetch, low otherwise.
- R10: On an exception the faulting address is loaded into bad_vaddr, ctx_reg[22:4] is loaded from address[31:13] and ctx_reg[31:23] and ctx_reg[3:0] are kept.
- R11: On an exception entry_hi becomes address[31:13] in bits 31:13, zero in bits 12:8, with its identifier bits 7:0 kept.
- R12: A result of 0, or flt_valid low, raises no exception and leaves bad_vaddr, ctx_reg, entry_hi and the exception outputs unchanged; exc_valid is high exactly in the cycle after an accepted failing result.
- R13: sw_wr loads ctx_reg[31:23] from sw_ctx_hi and entry_hi[7:0] from sw_id, keeping all other bits; when an exception is recorded in the same cycle the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Address request strobe |
| req_vaddr | input | 32 | Virtual address to route |
| req_mode | input | 2 | Privilege level: 0 kernel, 1 supervisor, 2 user, 3 kernel |
| req_err_level | input | 1 | Error-level state bit |
| rsp_valid | output | 1 | Response strobe, one cycle after a request |
| rsp_route | output | 2 | 0 unmapped, 1 page-table lookup, 2 refused |
| rsp_addr | output | 32 | Physical address (route 0), virtual address (route 1), zero (route 2) |
| flt_valid | input | 1 | Translation result strobe |
| flt_result | input | 3 | Translation result code |
| flt_vaddr | input | 32 | Address the result belongs to |
| flt_access | input | 2 | Access type: 0 load, 1 store, 2 fetch |
| inhibit_exc_en | input | 1 | Enables the dedicated inhibit exceptions |
| sw_wr | input | 1 | Load the kept context and identifier fields |
| sw_ctx_hi | input | 9 | New value of ctx_reg[31:23] |
| sw_id | input | 8 | New value of entry_hi[7:0] |
| exc_valid | output | 1 | Exception strobe |
| exc_code | output | 3 | Exception kind |
| exc_refill | output | 1 | No-entry flag |
| exc_fetch_na | output | 1 | Instruction-not-available flag |
| bad_vaddr | output | 32 | Last faulting address |
| ctx_reg | output | 32 | Context register |
| entry_hi | output | 32 | Entry-high register |

## Verification
The embedded properties assume that the reset input is held long enough for the internal two-stage release to clear, and that every input is a known value at each clock edge while the block is out of reset; the stimulus drives every input on the falling edge from a defined value, idles for several cycles after releasing reset, and never leaves a field undriven. They also take the result and access encodings as complete, so the bench sweeps all eight result codes and all four access types, including the two codes that fall back to defaults. Collisions between a software write and a fault, and between a request and a fault, are produced deliberately as well as by the random phase.

// File: rtl/segflt_pkg.sv
package segflt_pkg;

  localparam int VA_W = 32;

  // privilege levels
  localparam logic [1:0] LVL_KERNEL = 2'd0;
  localparam logic [1:0] LVL_SUPER  = 2'd1;
  localparam logic [1:0] LVL_USER   = 2'd2;

  typedef enum logic [1:0] {
    ROUTE_DIRECT = 2'd0,
    ROUTE_LOOKUP = 2'd1,
    ROUTE_REFUSE = 2'd2
  } route_e;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_SPARE = 2'd3
  } access_e;

  typedef enum logic [2:0] {
    RES_OK      = 3'd0,
    RES_REFUSED = 3'd1,
    RES_NOENTRY = 3'd2,
    RES_NOTVAL  = 3'd3,
    RES_CLEAN   = 3'd4,
    RES_RDINH   = 3'd5,
    RES_EXINH   = 3'd6,
    RES_SPARE   = 3'd7
  } result_e;

  typedef enum logic [2:0] {
    EXC_ADDR_LD = 3'd0,
    EXC_ADDR_ST = 3'd1,
    EXC_PT_LD   = 3'd2,
    EXC_PT_ST   = 3'd3,
    EXC_MODIFY  = 3'd4,
    EXC_RD_INH  = 3'd5,
    EXC_EX_INH  = 3'd6
  } exc_e;

endpackage

// File: rtl/seg_decode.sv
module seg_decode
  import segflt_pkg::*;
(
  input  logic [VA_W-1:0] vaddr,
  input  logic [1:0]      mode,
  input  logic            err_level,
  output route_e          route,
  output logic [VA_W-1:0] addr
);

  localparam int SEG_W = 3;
  localparam int OFS_W = VA_W - SEG_W;

  logic lvl_kernel;
  logic lvl_super;

  assign lvl_super  = (mode == LVL_SUPER);
  assign lvl_kernel = (mode != LVL_SUPER) && (mode != LVL_USER);

  always_comb begin
    route = ROUTE_REFUSE;
    addr  = '0;
    if (!vaddr[VA_W-1]) begin
      // low half: open to all levels
      addr  = vaddr;
      route = err_level ? ROUTE_DIRECT : ROUTE_LOOKUP;
    end else begin
      unique case (vaddr[VA_W-1 -: SEG_W])
        3'b100, 3'b101: begin
          if (lvl_kernel) begin
            route = ROUTE_DIRECT;
            addr  = {{SEG_W{1'b0}}, vaddr[OFS_W-1:0]};
          end
        end
        3'b110: begin
          if (lvl_kernel || lvl_super) begin
            route = ROUTE_LOOKUP;
            addr  = vaddr;
          end
        end
        default: begin
          if (lvl_kernel) begin
            route = ROUTE_LOOKUP;
            addr  = vaddr;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/fault_classify.sv
module fault_classify
  import segflt_pkg::*;
(
  input  logic [2:0] result,
  input  logic [1:0] access,
  input  logic       inh_en,
  output exc_e       code,
  output logic       refill,
  output logic       fetch_na
);

  logic is_store;

  assign is_store = (access == ACC_STORE);
  assign fetch_na = (access == ACC_FETCH);

  always_comb begin
    refill = 1'b0;
    unique case (result)
      RES_NOENTRY: begin
        code   = is_store ? EXC_PT_ST : EXC_PT_LD;
        refill = 1'b1;
      end
      RES_NOTVAL:  code = is_store ? EXC_PT_ST : EXC_PT_LD;
      RES_CLEAN:   code = EXC_MODIFY;
      RES_RDINH:   code = inh_en ? EXC_RD_INH : EXC_PT_LD;
      RES_EXINH:   code = inh_en ? EXC_EX_INH : EXC_PT_LD;
      default:     code = is_store ? EXC_ADDR_ST : EXC_ADDR_LD;
    endcase
  end

endmodule

// File: rtl/fault_regs.sv
module fault_regs
  import segflt_pkg::*;
#(
  parameter int ID_W    = 8,
  parameter int VPN_LSB = 13,
  parameter int CTX_LSB = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       capture,
  input  logic [VA_W-1:0]            vaddr,
  input  logic                       sw_wr,
  input  logic [VPN_LSB-CTX_LSB-1:0] sw_ctx_hi,
  input  logic [ID_W-1:0]            sw_id,
  output logic [VA_W-1:0]            bad_vaddr,
  output logic [VA_W-1:0]            ctx_reg,
  output logic [VA_W-1:0]            entry_hi
);

  localparam int VPN_W    = VA_W - VPN_LSB;
  localparam int CTX_HI_W = VPN_LSB - CTX_LSB;

  logic [VA_W-1:0] bad_q, bad_n;
  logic [VA_W-1:0] ctx_q, ctx_n;
  logic [VA_W-1:0] eh_q,  eh_n;
  logic            bad_en, ctx_en, eh_en;

  assign bad_en = capture;
  assign ctx_en = capture || sw_wr;
  assign eh_en  = capture || sw_wr;

  always_comb begin
    bad_n = vaddr;
    ctx_n = ctx_q;
    eh_n  = eh_q;
    if (capture) begin
      ctx_n[CTX_LSB +: VPN_W] = vaddr[VA_W-1:VPN_LSB];
      eh_n                    = {vaddr[VA_W-1:VPN_LSB], {VPN_LSB{1'b0}}};
      eh_n[ID_W-1:0]          = eh_q[ID_W-1:0];
    end else if (sw_wr) begin
      ctx_n[VA_W-1 -: CTX_HI_W] = sw_ctx_hi;
      eh_n[ID_W-1:0]            = sw_id;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bad_q <= '0;
      ctx_q <= '0;
      eh_q  <= '0;
    end else begin
      if (bad_en) bad_q <= bad_n;
      if (ctx_en) ctx_q <= ctx_n;
      if (eh_en)  eh_q  <= eh_n;
    end
  end

  assign bad_vaddr = bad_q;
  assign ctx_reg   = ctx_q;
  assign entry_hi  = eh_q;

  // R12: with neither a fault nor a write, all three registers hold
  p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!capture && !sw_wr) |=> ($stable(bad_q) && $stable(ctx_q) && $stable(eh_q)));

  // R10: a recorded fault keeps the high context field and low bits
  p_ctx_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (ctx_q[VA_W-1 -: CTX_HI_W] == $past(ctx_q[VA_W-1 -: CTX_HI_W]))
                && (ctx_q[CTX_LSB-1:0] == $past(ctx_q[CTX_LSB-1:0])));

  // R11: the identifier field survives a fault
  p_id_kept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (eh_q[ID_W-1:0] == $past(eh_q[ID_W-1:0])));

  // R13: a software write alone leaves the faulting address alone
  p_sw_no_bad_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr && !capture) |=> $stable(bad_q));

endmodule

// File: rtl/seg_fault_unit.sv
module seg_fault_unit
  import segflt_pkg::*;
#(
  parameter int ID_W    = 8,
  parameter int VPN_LSB = 13,
  parameter int CTX_LSB = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic [31:0]                req_vaddr,
  input  logic [1:0]                 req_mode,
  input  logic                       req_err_level,
  output logic                       rsp_valid,
  output logic [1:0]                 rsp_route,
  output logic [31:0]                rsp_addr,
  input  logic                       flt_valid,
  input  logic [2:0]                 flt_result,
  input  logic [31:0]                flt_vaddr,
  input  logic [1:0]                 flt_access,
  input  logic                       inhibit_exc_en,
  input  logic                       sw_wr,
  input  logic [VPN_LSB-CTX_LSB-1:0] sw_ctx_hi,
  input  logic [ID_W-1:0]            sw_id,
  output logic                       exc_valid,
  output logic [2:0]                 exc_code,
  output logic                       exc_refill,
  output logic                       exc_fetch_na,
  output logic [31:0]                bad_vaddr,
  output logic [31:0]                ctx_reg,
  output logic [31:0]                entry_hi
);

  localparam int RST_STAGES = 2;

  // asynchronous assert, synchronous release
  logic [RST_STAGES-1:0] rst_pipe;
  logic                  core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
  end
  assign core_rst_n = rst_pipe[RST_STAGES-1];

  // segment routing
  route_e          seg_route;
  logic [VA_W-1:0] seg_addr;

  seg_decode u_seg (
    .vaddr     (req_vaddr),
    .mode      (req_mode),
    .err_level (req_err_level),
    .route     (seg_route),
    .addr      (seg_addr)
  );

  route_e          route_q, route_n;
  logic [VA_W-1:0] addr_q,  addr_n;
  logic            rv_q,    rv_n;
  logic            rsp_en;

  assign rsp_en = req_valid;

  always_comb begin
    rv_n    = req_valid;
    route_n = seg_route;
    addr_n  = seg_addr;
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      rv_q    <= 1'b0;
      route_q <= ROUTE_DIRECT;
      addr_q  <= '0;
    end else begin
      rv_q <= rv_n;
      if (rsp_en) begin
        route_q <= route_n;
        addr_q  <= addr_n;
      end
    end
  end

  assign rsp_valid = rv_q;
  assign rsp_route = route_q;
  assign rsp_addr  = addr_q;

  // fault classification
  exc_e cls_code;
  logic cls_refill;
  logic cls_fetch;
  logic capture;

  assign capture = flt_valid && (flt_result != RES_OK);

  fault_classify u_cls (
    .result   (flt_result),
    .access   (flt_access),
    .inh_en   (inhibit_exc_en),
    .code     (cls_code),
    .refill   (cls_refill),
    .fetch_na (cls_fetch)
  );

  exc_e code_q,   code_n;
  logic refill_q, refill_n;
  logic fetch_q,  fetch_n;
  logic ev_q,     ev_n;

  always_comb begin
    ev_n     = capture;
    code_n   = cls_code;
    refill_n = cls_refill;
    fetch_n  = cls_fetch;
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      ev_q     <= 1'b0;
      code_q   <= EXC_ADDR_LD;
      refill_q <= 1'b0;
      fetch_q  <= 1'b0;
    end else begin
      ev_q <= ev_n;
      if (capture) begin
        code_q   <= code_n;
        refill_q <= refill_n;
        fetch_q  <= fetch_n;
      end
    end
  end

  assign exc_valid    = ev_q;
  assign exc_code     = code_q;
  assign exc_refill   = refill_q;
  assign exc_fetch_na = fetch_q;

  fault_regs #(
    .ID_W    (ID_W),
    .VPN_LSB (VPN_LSB),
    .CTX_LSB (CTX_LSB)
  ) u_regs (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .capture   (capture),
    .vaddr     (flt_vaddr),
    .sw_wr     (sw_wr),
    .sw_ctx_hi (sw_ctx_hi),
    .sw_id     (sw_id),
    .bad_vaddr (bad_vaddr),
    .ctx_reg   (ctx_reg),
    .entry_hi  (entry_hi)
  );

  // R5: response strobe tracks the request one cycle later
  p_rsp_follows_r5: assert property (@(posedge clk) disable iff (!core_rst_n)
    req_valid |=> rsp_valid);
  p_rsp_quiet_r5: assert property (@(posedge clk) disable iff (!core_rst_n)
    !req_valid |=> (!rsp_valid && $stable(rsp_addr) && $stable(rsp_route)));

  // R4: user level never reaches the upper half
  p_user_refused_r4: assert property (@(posedge clk) disable iff (!core_rst_n)
    (req_valid && req_mode == LVL_USER && req_vaddr[31]) |=> (rsp_route == ROUTE_REFUSE));

  // R2 / R3: refused answers carry no address
  p_refuse_zero_r2: assert property (@(posedge clk) disable iff (!core_rst_n)
    (rsp_valid && rsp_route == ROUTE_REFUSE) |-> (rsp_addr == '0));

  // R7: the refill flag only accompanies page-table load/store kinds
  p_refill_kind_r7: assert property (@(posedge clk) disable iff (!core_rst_n)
    (exc_valid && exc_refill) |-> (exc_code == EXC_PT_LD || exc_code == EXC_PT_ST));

  // R12: a success result raises nothing
  p_ok_silent_r12: assert property (@(posedge clk) disable iff (!core_rst_n)
    (!flt_valid || flt_result == RES_OK) |=> !exc_valid);

  // R10 / R11: page-number fields of context and entry-high agree with the address
  p_vpn_agree_r10: assert property (@(posedge clk) disable iff (!core_rst_n)
    exc_valid |-> (ctx_reg[CTX_LSB +: VA_W-VPN_LSB] == bad_vaddr[VA_W-1:VPN_LSB])
                  && (entry_hi[VA_W-1:VPN_LSB] == bad_vaddr[VA_W-1:VPN_LSB]));
  p_eh_gap_r11: assert property (@(posedge clk) disable iff (!core_rst_n)
    exc_valid |-> (entry_hi[VPN_LSB-1:ID_W] == '0));

  // R9: instruction-not-available only with a fetch
  p_fetch_flag_r9: assert property (@(posedge clk) disable iff (!core_rst_n)
    (flt_valid && flt_result != RES_OK) |=> (exc_fetch_na == $past(flt_access == ACC_FETCH)));

endmodule

// File: tb/seg_fault_unit_test.sv
module seg_fault_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_mode = '0;
  logic        req_err_level = 1'b0;
  logic        flt_valid = 1'b0;
  logic [2:0]  flt_result = '0;
  logic [31:0] flt_vaddr = '0;
  logic [1:0]  flt_access = '0;
  logic        inhibit_exc_en = 1'b0;
  logic        sw_wr = 1'b0;
  logic [8:0]  sw_ctx_hi = '0;
  logic [7:0]  sw_id = '0;

  logic        rsp_valid;
  logic [1:0]  rsp_route;
  logic [31:0] rsp_addr;
  logic        exc_valid;
  logic [2:0]  exc_code;
  logic        exc_refill;
  logic        exc_fetch_na;
  logic [31:0] bad_vaddr;
  logic [31:0] ctx_reg;
  logic [31:0] entry_hi;

  int n_cmp = 0;
  int n_bad = 0;
  bit running = 1'b0;

  always #2 clk = ~clk;

  seg_fault_unit uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_mode(req_mode),
    .req_err_level(req_err_level),
    .rsp_valid(rsp_valid), .rsp_route(rsp_route), .rsp_addr(rsp_addr),
    .flt_valid(flt_valid), .flt_result(flt_result), .flt_vaddr(flt_vaddr),
    .flt_access(flt_access), .inhibit_exc_en(inhibit_exc_en),
    .sw_wr(sw_wr), .sw_ctx_hi(sw_ctx_hi), .sw_id(sw_id),
    .exc_valid(exc_valid), .exc_code(exc_code), .exc_refill(exc_refill),
    .exc_fetch_na(exc_fetch_na),
    .bad_vaddr(bad_vaddr), .ctx_reg(ctx_reg), .entry_hi(entry_hi)
  );

  // ---------------- reference model ----------------
  bit          m_rv;
  int          m_route;
  logic [31:0] m_addr;
  bit          m_ev;
  int          m_code;
  bit          m_refill;
  bit          m_fetch;
  logic [31:0] m_bad, m_ctx, m_eh;
  string       t_rsp, t_code, t_ctx, t_eh;

  task automatic model_reset();
    m_rv = 0; m_route = 0; m_addr = '0;
    m_ev = 0; m_code = 0; m_refill = 0; m_fetch = 0;
    m_bad = '0; m_ctx = '0; m_eh = '0;
    t_rsp = "R5"; t_code = "R5"; t_ctx = "R5"; t_eh = "R5";
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) begin
      model_reset();
    end else begin
      bit kern, sup, st;
      kern = (req_mode == 2'd0) || (req_mode == 2'd3);
      sup  = (req_mode == 2'd1);
      m_rv = req_valid;
      if (req_valid) begin
        if (req_vaddr <= 32'h7FFF_FFFF) begin
          t_rsp = "R1";
          m_route = req_err_level ? 0 : 1;
          m_addr = req_vaddr;
        end else if (req_vaddr < 32'hA000_0000) begin
          t_rsp = "R2";
          m_route = kern ? 0 : 2;
          m_addr = kern ? req_vaddr - 32'h8000_0000 : 32'h0;
        end else if (req_vaddr < 32'hC000_0000) begin
          t_rsp = "R3";
          m_route = kern ? 0 : 2;
          m_addr = kern ? req_vaddr - 32'hA000_0000 : 32'h0;
        end else if (req_vaddr < 32'hE000_0000) begin
          t_rsp = "R4";
          m_route = (kern || sup) ? 1 : 2;
          m_addr = (kern || sup) ? req_vaddr : 32'h0;
        end else begin
          t_rsp = "R4";
          m_route = kern ? 1 : 2;
          m_addr = kern ? req_vaddr : 32'h0;
        end
      end
      m_ev = flt_valid && (flt_result != 3'd0);
      st = (flt_access == 2'd1);
      if (m_ev) begin
        m_refill = 0;
        case (flt_result)
          3'd2: begin m_code = st ? 3 : 2; m_refill = 1; t_code = "R7"; end
          3'd3: begin m_code = st ? 3 : 2; t_code = "R7"; end
          3'd4: begin m_code = 4; t_code = "R8"; end
          3'd5: begin m_code = inhibit_exc_en ? 5 : 2; t_code = "R8"; end
          3'd6: begin m_code = inhibit_exc_en ? 6 : 2; t_code = "R8"; end
          default: begin m_code = st ? 1 : 0; t_code = "R6"; end
        endcase
        m_fetch = (flt_access == 2'd2);
        m_bad = flt_vaddr;
        m_ctx = (m_ctx & ~32'h007F_FFF0) | ((flt_vaddr >> 9) & 32'h007F_FFF0);
        m_eh  = (m_eh & 32'h0000_00FF) | (flt_vaddr & 32'hFFFF_E000);
        t_ctx = "R10"; t_eh = "R11";
      end else if (sw_wr) begin
        m_ctx = (m_ctx & 32'h007F_FFFF) | ({23'd0, sw_ctx_hi} << 23);
        m_eh  = (m_eh & 32'hFFFF_FF00) | {24'd0, sw_id};
        t_ctx = "R13"; t_eh = "R13";
      end
    end
  end

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (running) begin
      chk("R5",  "rsp_valid", {31'd0, rsp_valid}, {31'd0, m_rv});
      chk(t_rsp, "rsp_route", {30'd0, rsp_route}, m_route);
      chk(t_rsp, "rsp_addr",  rsp_addr, m_addr);
      chk("R12", "exc_valid", {31'd0, exc_valid}, {31'd0, m_ev});
      chk(t_code, "exc_code", {29'd0, exc_code}, m_code);
      chk("R7",  "exc_refill", {31'd0, exc_refill}, {31'd0, m_refill});
      chk("R9",  "exc_fetch_na", {31'd0, exc_fetch_na}, {31'd0, m_fetch});
      chk("R10", "bad_vaddr", bad_vaddr, m_bad);
      chk(t_ctx, "ctx_reg", ctx_reg, m_ctx);
      chk(t_eh,  "entry_hi", entry_hi, m_eh);
    end
  end

  // ---------------- stimulus ----------------
  task automatic idle();
    req_valid = 0; flt_valid = 0; sw_wr = 0;
  endtask

  task automatic do_req(input logic [31:0] va, input logic [1:0] md, input logic el);
    req_valid = 1; req_vaddr = va; req_mode = md; req_err_level = el;
  endtask

  task automatic do_flt(input logic [2:0] res, input logic [31:0] va,
                        input logic [1:0] acc, input logic inh);
    flt_valid = 1; flt_result = res; flt_vaddr = va; flt_access = acc;
    inhibit_exc_en = inh;
  endtask

  task automatic do_sw(input logic [8:0] hi, input logic [7:0] id);
    sw_wr = 1; sw_ctx_hi = hi; sw_id = id;
  endtask

  localparam int NB = 10;
  logic [31:0] edges [NB] = '{32'h0000_0000, 32'h7FFF_FFFF, 32'h8000_0000,
    32'h9FFF_FFFF, 32'hA000_0000, 32'hBFFF_FFFF, 32'hC000_0000,
    32'hDFFF_FFFF, 32'hE000_0000, 32'hFFFF_FFFF};

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    running = 1'b1;          // R5: first comparisons see the reset state
    @(negedge clk);

    // R1..R4: every boundary in every level and error-level state
    for (int b = 0; b < NB; b++) begin
      for (int md = 0; md < 4; md++) begin
        for (int el = 0; el < 2; el++) begin
          do_req(edges[b], md[1:0], el[0]);
          @(negedge clk);
        end
      end
    end
    idle(); @(negedge clk); @(negedge clk);   // R5: outputs hold

    // R13: load the kept fields
    do_sw(9'h1A5, 8'h3C); @(negedge clk); idle(); @(negedge clk);

    // R6..R9: every result code, access type and inhibit setting
    for (int r = 0; r < 8; r++) begin
      for (int a = 0; a < 4; a++) begin
        for (int ih = 0; ih < 2; ih++) begin
          do_flt(r[2:0], 32'h1234_5678 ^ (r << 28) ^ (a << 14) ^ ih, a[1:0], ih[0]);
          @(negedge clk);
          idle(); @(negedge clk);  // R12: registers hold with no fault
        end
      end
    end

    // R12: success and strobe-low results change nothing
    do_flt(3'd0, 32'hDEAD_BEEF, 2'd1, 1'b1); @(negedge clk);
    flt_valid = 0; flt_result = 3'd2; @(negedge clk);
    idle(); @(negedge clk);

    // R13: write and fault in the same cycle, then write alone
    do_sw(9'h0FF, 8'hA5); do_flt(3'd2, 32'hFEDC_BA98, 2'd2, 1'b0); @(negedge clk);
    idle(); do_sw(9'h155, 8'h5A); @(negedge clk);
    idle(); @(negedge clk);
    // R11: identifier kept across a fault
    do_flt(3'd4, 32'h0000_3FFF, 2'd1, 1'b0); @(negedge clk);
    idle(); @(negedge clk);

    // mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      req_valid = $urandom_range(0, 1); req_vaddr = $urandom;
      req_mode = 2'($urandom_range(0, 3)); req_err_level = $urandom_range(0, 1);
      flt_valid = $urandom_range(0, 1); flt_result = 3'($urandom_range(0, 7));
      flt_vaddr = $urandom; flt_access = 2'($urandom_range(0, 3));
      inhibit_exc_en = $urandom_range(0, 1);
      sw_wr = ($urandom_range(0, 3) == 0); sw_ctx_hi = 9'($urandom); sw_id = 8'($urandom);
      @(negedge clk);
    end
    idle(); @(negedge clk); @(negedge clk);

    running = 1'b0;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule